// File: doc/BRIEF.md
# Peripheral-to-Memory DMA Stream Channel

This block is a single DMA channel that moves data from a slow peripheral into memory. Items arrive on a valid/ready handshake and are held in a small FIFO. They leave on a simple write-master port. The channel does not ask for the bus on every item. It waits until the FIFO has filled to a selectable level and then writes either one beat or a burst of a programmed length. Because the bus is requested only in those short bursts, it stays free for other masters in between.

A start pulse loads a 16-bit item count and begins a block. Each item is either a byte or a full 32-bit word, and the write address steps by the item size. When the last item of a block is written, the channel raises a one-cycle completion pulse. In double-buffer mode the channel keeps running on its own. At each block end it switches to the other of two base pointers, so software can work on the idle buffer while the active one fills. Arbitration and the peripheral itself sit outside this block.

Top module: `dma_stream_channel`

## Requirements
- R1: The FIFO holds 4 items; `per_ready_o` is high only while the channel is active, the block still expects items, and the FIFO is not full. An item is taken on a clock edge where both valid and ready are high.
- R2: A start pulse with a nonzero count (1 to 65535) begins a block that accepts exactly that many items and writes exactly that many beats. A start with count 0, or a start while the channel is active, has no effect.
- R3: The drain level code `thr_sel_i` maps 0, 1, 2, 3 to 1, 2, 3, 4 FIFO items. No write is requested while the fill is below that level, except during a flush. `mem_req_o` rises one cycle after the fill reaches the level.
- R4: With bursts enabled and the fill at the level, one transaction carries min(`burst_len_i`+1, level) beats. `mem_len_o` shows beats-1 and stays constant, and `mem_req_o` stays high until every beat has been granted. Each cycle with `mem_req_o` and `mem_gnt_i` both high transfers one beat.
- R5: With bursts disabled, every transaction is a single beat with `mem_len_o` = 0. After the last beat of any transaction, `mem_req_o` is low for at least one cycle.
- R6: In word mode (`byte_mode_i`=0) the address steps by 4, `mem_strb_o` is 4'b1111, and `mem_wdata_o` is the item. In byte mode the address steps by 1, `mem_strb_o` has only bit `mem_addr_o[1:0]` set, and that byte lane carries the item's low byte.
- R7: Once all items of a block have arrived, any items still in the FIFO are written as single beats. `blk_done_o` pulses for exactly one cycle, in the cycle right after the block's last beat.
- R8: In double-buffer mode (`dbuf_en_i`=1 at block end), `cur_buf_o` toggles at block end, the next address reloads from the newly selected base (`base1_i` when `cur_buf_o`=1, `base0_i` when 0), and the next block of the same count begins without a new start. With the mode off at block end, `cur_buf_o` is left as it is.
- R9: A start always selects buffer 0 (`base0_i`). Outside double-buffer mode the channel stops after the block, with `per_ready_o` and `mem_req_o` low until the next start.
- R10: After reset, `mem_req_o`, `per_ready_o`, `cur_buf_o` and `blk_done_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| start_i | input | 1 | One-cycle pulse that begins a block |
| xfer_count_i | input | 16 | Items per block |
| burst_en_i | input | 1 | Enable multi-beat transactions |
| burst_len_i | input | 2 | Burst beats minus one |
| thr_sel_i | input | 2 | Drain level code |
| byte_mode_i | input | 1 | 1: byte items, 0: word items |
| dbuf_en_i | input | 1 | Double-buffer mode |
| base0_i | input | 32 | Base address of buffer 0 |
| base1_i | input | 32 | Base address of buffer 1 |
| per_data_i | input | 32 | Peripheral item |
| per_valid_i | input | 1 | Peripheral item valid |
| per_ready_o | output | 1 | Channel can take an item |
| mem_req_o | output | 1 | Write transaction request |
| mem_addr_o | output | 32 | Address of the current beat |
| mem_wdata_o | output | 32 | Data of the current beat |
| mem_strb_o | output | 4 | Byte-lane strobes |
| mem_len_o | output | 2 | Transaction beats minus one |
| mem_gnt_i | input | 1 | Beat accepted this cycle |
| cur_buf_o | output | 1 | Buffer currently in use |
| blk_done_o | output | 1 | Block-complete pulse |

## Verification
The drain rule is swept over every level code, every burst length, bursts on and off, byte and word items, and block sizes of 1, 5 and 9. The blocks of 1 and 5 items end below the level, so they separate a proper end-of-block flush from a channel that stalls or writes an early burst. Blocks of 9 items cover steady bursts. Grant is either held high or dropped every third cycle, which separates a beat counter that moves on grant from one that moves on request. Directed runs then cover:
- the exact cycle in which the request rises at the level;
- a full FIFO with the grant held low;
- a double-buffer run with the swap turned off part way;
- a zero-count start;
- a block of 65535 items.

Every beat's address, lane, data and buffer flag are compared against arithmetic from the item index.

// File: rtl/dma_stream_pkg.sv
package dma_stream_pkg;

    typedef enum logic {
        BUS_IDLE = 1'b0,
        BUS_XFER = 1'b1
    } bus_state_e;

    // Number of FIFO items that a drain level code stands for (quarters of the depth).
    function automatic int unsigned level_items(input logic [1:0] code, input int unsigned depth);
        return (int'(code) + 1) * (depth / 4);
    endfunction

endpackage

// File: rtl/dma_stream_fifo.sv
module dma_stream_fifo #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              push_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              pop_i,
    output logic [DATA_W-1:0] head_o,
    output logic [LVL_W-1:0]  level_o,
    output logic              full_o,
    output logic              empty_o
);

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] mem;
        logic [PTR_W-1:0]             wr;
        logic [PTR_W-1:0]             rd;
        logic [LVL_W-1:0]             lvl;
    } fifo_state_t;

    fifo_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (push_i) begin
            st_d.mem[st_q.wr] = data_i;
            st_d.wr = (st_q.wr == PTR_W'(DEPTH - 1)) ? '0 : st_q.wr + 1'b1;
        end
        if (pop_i) begin
            st_d.rd = (st_q.rd == PTR_W'(DEPTH - 1)) ? '0 : st_q.rd + 1'b1;
        end
        case ({push_i, pop_i})
            2'b10:   st_d.lvl = st_q.lvl + 1'b1;
            2'b01:   st_d.lvl = st_q.lvl - 1'b1;
            default: st_d.lvl = st_q.lvl;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign head_o  = st_q.mem[st_q.rd];
    assign level_o = st_q.lvl;
    assign full_o  = (st_q.lvl == LVL_W'(DEPTH));
    assign empty_o = (st_q.lvl == '0);

    // R1: storage never overflows or underflows
    assert_push_space_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        push_i |-> !full_o);
    assert_pop_data_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pop_i |-> !empty_o);
    assert_level_bound_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.lvl <= LVL_W'(DEPTH));

endmodule

// File: rtl/dma_stream_drain.sv
module dma_stream_drain
    import dma_stream_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int LEN_W = 2,
    localparam int LVL_W  = $clog2(DEPTH + 1),
    localparam int BEAT_W = LEN_W + 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             active_i,
    input  logic             flush_i,
    input  logic [LVL_W-1:0] level_i,
    input  logic [1:0]       thr_sel_i,
    input  logic             burst_en_i,
    input  logic [LEN_W-1:0] burst_len_i,
    input  logic             gnt_i,
    output logic             req_o,
    output logic [LEN_W-1:0] len_o,
    output logic             pop_o
);

    typedef struct packed {
        bus_state_e        st;
        logic [LEN_W-1:0]  len;
        logic [BEAT_W-1:0] left;
    } drain_state_t;

    drain_state_t dr_d, dr_q;

    int unsigned lvl_need;
    int unsigned want_beats;
    int unsigned burst_beats;
    logic        at_level;

    always_comb begin
        lvl_need    = level_items(thr_sel_i, DEPTH);
        want_beats  = 32'(burst_len_i) + 1;
        burst_beats = (want_beats > lvl_need) ? lvl_need : want_beats;
        at_level    = 32'(level_i) >= lvl_need;

        dr_d = dr_q;
        case (dr_q.st)
            BUS_IDLE: begin
                if (active_i) begin
                    if (burst_en_i && at_level) begin
                        dr_d.st   = BUS_XFER;
                        dr_d.len  = LEN_W'(burst_beats - 1);
                        dr_d.left = BEAT_W'(burst_beats);
                    end else if ((flush_i && level_i != '0) || (!burst_en_i && at_level)) begin
                        dr_d.st   = BUS_XFER;
                        dr_d.len  = '0;
                        dr_d.left = BEAT_W'(1);
                    end
                end
            end
            BUS_XFER: begin
                if (gnt_i) begin
                    dr_d.left = dr_q.left - 1'b1;
                    if (dr_q.left == BEAT_W'(1)) begin
                        dr_d.st = BUS_IDLE;
                    end
                end
            end
            default: dr_d.st = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            dr_q <= '{st: BUS_IDLE, len: '0, left: '0};
        end else begin
            dr_q <= dr_d;
        end
    end

    assign req_o = (dr_q.st == BUS_XFER);
    assign len_o = dr_q.len;
    assign pop_o = req_o && gnt_i;

    // R4: an open transaction keeps its request and length until its last beat
    assert_burst_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_o && !(gnt_i && dr_q.left == BEAT_W'(1)) |=> req_o && $stable(len_o));
    // R5: the bus is released after every transaction
    assert_release_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_o && gnt_i && dr_q.left == BEAT_W'(1) |=> !req_o);
    assert_single_beat_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_o && !burst_en_i |-> len_o == '0);
    // R3: a request only opens when the FIFO holds data
    assert_req_has_data_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(req_o) |-> $past(level_i) != '0);

endmodule

// File: rtl/dma_stream_block.sv
module dma_stream_block #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int STRB_W = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic              dbuf_en_i,
    input  logic              byte_mode_i,
    input  logic [ADDR_W-1:0] base0_i,
    input  logic [ADDR_W-1:0] base1_i,
    input  logic              push_i,
    input  logic              beat_i,
    output logic              active_o,
    output logic              accept_o,
    output logic              flush_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              cur_buf_o,
    output logic              done_o
);

    typedef struct packed {
        logic              active;
        logic [CNT_W-1:0]  in_left;
        logic [CNT_W-1:0]  out_left;
        logic [ADDR_W-1:0] addr;
        logic              cur_buf;
        logic              done;
    } blk_state_t;

    blk_state_t bk_d, bk_q;
    logic [ADDR_W-1:0] step;
    logic              next_buf;

    always_comb begin
        step     = byte_mode_i ? ADDR_W'(1) : ADDR_W'(STRB_W);
        next_buf = ~bk_q.cur_buf;
        bk_d      = bk_q;
        bk_d.done = 1'b0;
        if (!bk_q.active) begin
            if (start_i && count_i != '0) begin
                bk_d.active   = 1'b1;
                bk_d.in_left  = count_i;
                bk_d.out_left = count_i;
                bk_d.addr     = base0_i;
                bk_d.cur_buf  = 1'b0;
            end
        end else begin
            if (push_i) begin
                bk_d.in_left = bk_q.in_left - 1'b1;
            end
            if (beat_i) begin
                bk_d.addr     = bk_q.addr + step;
                bk_d.out_left = bk_q.out_left - 1'b1;
                if (bk_q.out_left == CNT_W'(1)) begin
                    bk_d.done = 1'b1;
                    if (dbuf_en_i && count_i != '0) begin
                        bk_d.cur_buf  = next_buf;
                        bk_d.addr     = next_buf ? base1_i : base0_i;
                        bk_d.in_left  = count_i;
                        bk_d.out_left = count_i;
                    end else begin
                        bk_d.active = 1'b0;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            bk_q <= '0;
        end else begin
            bk_q <= bk_d;
        end
    end

    assign active_o  = bk_q.active;
    assign accept_o  = bk_q.active && (bk_q.in_left != '0);
    assign flush_o   = bk_q.active && (bk_q.in_left == '0);
    assign addr_o    = bk_q.addr;
    assign cur_buf_o = bk_q.cur_buf;
    assign done_o    = bk_q.done;

    // R7: completion is a single-cycle pulse
    assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);
    // R8: the buffer flag only moves at a block end or on a start
    assert_swap_at_end_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(cur_buf_o) |-> done_o || $past(start_i));
    // R2: items written never run ahead of items taken, and no item is taken past the count
    assert_out_behind_in_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bk_q.out_left >= bk_q.in_left);
    assert_no_extra_item_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        push_i |-> bk_q.active && bk_q.in_left != '0);

endmodule

// File: rtl/dma_stream_channel.sv
module dma_stream_channel #(
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 32,
    parameter int FIFO_DEPTH = 4,
    parameter int CNT_W      = 16,
    parameter int LEN_W      = 2,
    localparam int STRB_W = DATA_W / 8,
    localparam int LANE_W = (STRB_W > 1) ? $clog2(STRB_W) : 1,
    localparam int LVL_W  = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic [CNT_W-1:0]  xfer_count_i,
    input  logic              burst_en_i,
    input  logic [LEN_W-1:0]  burst_len_i,
    input  logic [1:0]        thr_sel_i,
    input  logic              byte_mode_i,
    input  logic              dbuf_en_i,
    input  logic [ADDR_W-1:0] base0_i,
    input  logic [ADDR_W-1:0] base1_i,
    input  logic [DATA_W-1:0] per_data_i,
    input  logic              per_valid_i,
    output logic              per_ready_o,
    output logic              mem_req_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    output logic [STRB_W-1:0] mem_strb_o,
    output logic [LEN_W-1:0]  mem_len_o,
    input  logic              mem_gnt_i,
    output logic              cur_buf_o,
    output logic              blk_done_o
);

    logic              push, pop, full, empty;
    logic              active, accept, flush;
    logic [LVL_W-1:0]  level;
    logic [DATA_W-1:0] head;

    assign per_ready_o = accept && !full;
    assign push        = per_valid_i && per_ready_o;

    dma_stream_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .push_i  (push),
        .data_i  (per_data_i),
        .pop_i   (pop),
        .head_o  (head),
        .level_o (level),
        .full_o  (full),
        .empty_o (empty)
    );

    dma_stream_drain #(.DEPTH(FIFO_DEPTH), .LEN_W(LEN_W)) u_drain (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .active_i    (active),
        .flush_i     (flush),
        .level_i     (level),
        .thr_sel_i   (thr_sel_i),
        .burst_en_i  (burst_en_i),
        .burst_len_i (burst_len_i),
        .gnt_i       (mem_gnt_i),
        .req_o       (mem_req_o),
        .len_o       (mem_len_o),
        .pop_o       (pop)
    );

    dma_stream_block #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .STRB_W(STRB_W)) u_block (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .start_i     (start_i),
        .count_i     (xfer_count_i),
        .dbuf_en_i   (dbuf_en_i),
        .byte_mode_i (byte_mode_i),
        .base0_i     (base0_i),
        .base1_i     (base1_i),
        .push_i      (push),
        .beat_i      (pop),
        .active_o    (active),
        .accept_o    (accept),
        .flush_o     (flush),
        .addr_o      (mem_addr_o),
        .cur_buf_o   (cur_buf_o),
        .done_o      (blk_done_o)
    );

    always_comb begin
        if (byte_mode_i) begin
            mem_strb_o  = STRB_W'(1) << mem_addr_o[LANE_W-1:0];
            mem_wdata_o = {STRB_W{head[7:0]}};
        end else begin
            mem_strb_o  = '1;
            mem_wdata_o = head;
        end
    end

    // R6: a byte beat enables exactly one lane
    assert_byte_lane_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mem_req_o && byte_mode_i |-> $countones(mem_strb_o) == 1);
    // R1: a request never presents an empty FIFO
    assert_req_not_empty_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mem_req_o |-> !empty);
    // R9: an inactive channel neither takes items nor requests the bus
    assert_idle_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !active |-> !per_ready_o && !mem_req_o);

endmodule

// File: tb/tb_dma_stream_channel.sv
module tb_dma_stream_channel;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_start = 1'b0;
    logic [15:0] cfg_count = '0;
    logic        cfg_burst = 1'b0;
    logic [1:0]  cfg_blen = '0;
    logic [1:0]  cfg_thr = '0;
    logic        cfg_byte = 1'b0;
    logic        cfg_dbuf = 1'b0;
    logic [31:0] cfg_base0 = '0;
    logic [31:0] cfg_base1 = '0;
    logic [31:0] per_data = '0;
    logic        per_valid = 1'b0;
    logic        per_ready;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [3:0]  mem_strb;
    logic [1:0]  mem_len;
    logic        mem_gnt = 1'b0;
    logic        cur_buf;
    logic        blk_done;

    always #10 clk = ~clk;

    dma_stream_channel dut (
        .clk_i(clk), .rst_ni(rst_n), .start_i(cfg_start), .xfer_count_i(cfg_count),
        .burst_en_i(cfg_burst), .burst_len_i(cfg_blen), .thr_sel_i(cfg_thr),
        .byte_mode_i(cfg_byte), .dbuf_en_i(cfg_dbuf), .base0_i(cfg_base0), .base1_i(cfg_base1),
        .per_data_i(per_data), .per_valid_i(per_valid), .per_ready_o(per_ready),
        .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
        .mem_strb_o(mem_strb), .mem_len_o(mem_len), .mem_gnt_i(mem_gnt),
        .cur_buf_o(cur_buf), .blk_done_o(blk_done)
    );

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int feed_n = 0, sent = 0, rcv = 0, blk_idx = 0, blocks = 0, last_beat_cyc = -10;
    int tx_beats = 0, run_count = 0, exp_b = 1, step = 4, gnt_mode = 0, cnt = 0;
    logic [1:0] tx_len = '0;
    bit in_tx = 0, exp_buf = 0, run_burst = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] pat(input int n);
        logic [31:0] nn;
        nn = n;
        return 32'hC3A5_0000 ^ (nn * 32'h0001_0F1D);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Drivers, then monitor, in one process at the falling edge
    always @(negedge clk) begin
        logic [31:0] ea, pv;
        int lane;
        case (gnt_mode)
            0: mem_gnt = 1'b0;
            1: mem_gnt = 1'b1;
            default: mem_gnt = (cyc % 3) != 0;
        endcase
        if (per_ready && sent < feed_n) begin
            per_valid = 1'b1;
            per_data  = pat(sent);
            sent++;
        end else begin
            per_valid = 1'b0;
        end
        if (rst_n) begin
            if (mem_req && !in_tx) begin
                in_tx = 1; tx_beats = 0; tx_len = mem_len;
                if (run_burst)
                    chk(mem_len == 2'd0 || int'(mem_len) == exp_b - 1, "R4 burst length", 32'(mem_len), 32'(exp_b - 1));
                else
                    chk(mem_len == 2'd0, "R5 single-beat length", 32'(mem_len), 0);
            end
            if (mem_req && mem_gnt) begin
                chk(mem_len == tx_len, "R4 length held", 32'(mem_len), 32'(tx_len));
                ea = (exp_buf ? cfg_base1 : cfg_base0) + 32'(blk_idx * step);
                pv = pat(rcv);
                chk(mem_addr == ea, "R6 beat address", mem_addr, ea);
                chk(cur_buf == exp_buf, "R8 buffer flag", 32'(cur_buf), 32'(exp_buf));
                if (cfg_byte) begin
                    lane = int'(ea[1:0]);
                    chk(mem_strb == (4'b0001 << lane), "R6 byte strobe", 32'(mem_strb), 32'(4'b0001 << lane));
                    chk(mem_wdata[8*lane +: 8] == pv[7:0], "R6 byte data", 32'(mem_wdata[8*lane +: 8]), 32'(pv[7:0]));
                end else begin
                    chk(mem_strb == 4'hF, "R6 word strobe", 32'(mem_strb), 32'hF);
                    chk(mem_wdata == pv, "R6 word data", mem_wdata, pv);
                end
                tx_beats++; rcv++; blk_idx++;
                if (blk_idx == run_count) last_beat_cyc = cyc;
            end
            if (!mem_req && in_tx) begin
                in_tx = 0;
                chk(tx_beats == int'(tx_len) + 1, "R4 beats per transaction", tx_beats, int'(tx_len) + 1);
            end
            if (blk_done) begin
                chk(blk_idx == run_count, "R7 items in block", blk_idx, run_count);
                chk(cyc == last_beat_cyc + 1, "R7 done one cycle after last beat", cyc, last_beat_cyc + 1);
                blk_idx = 0;
                blocks++;
                if (cfg_dbuf) exp_buf = ~exp_buf;
            end
        end
    end

    task automatic setup(input int thr, input int blen, input bit burst, input bit bytem,
                         input int count, input bit dbuf, input int gm);
        rst_n = 1'b0;
        cfg_start = 1'b0; cfg_thr = 2'(thr); cfg_blen = 2'(blen); cfg_burst = burst;
        cfg_byte = bytem; cfg_count = 16'(count); cfg_dbuf = dbuf;
        cfg_base0 = bytem ? 32'h4000_0003 : 32'h4000_0000;
        cfg_base1 = 32'h5000_0000;
        feed_n = 0; sent = 0; rcv = 0; blk_idx = 0; blocks = 0; in_tx = 0; exp_buf = 0;
        last_beat_cyc = -10; gnt_mode = gm; run_count = count; run_burst = burst;
        exp_b = (blen + 1 < thr + 1) ? blen + 1 : thr + 1;
        step = bytem ? 1 : 4;
        wait_cyc(2);
        rst_n = 1'b1;
        wait_cyc(1);
    endtask

    task automatic start_block();
        cfg_start = 1'b1;
        wait_cyc(1);
        cfg_start = 1'b0;
    endtask

    task automatic wait_blocks(input int n, input int limit, input string tag);
        int k = 0;
        while (blocks < n && k < limit) begin
            wait_cyc(1);
            k++;
        end
        chk(blocks >= n, tag, blocks, n);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired before the run completed actual=%0d expected=finish", cyc);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #1;
        // R10: reset state
        setup(0, 0, 0, 0, 4, 0, 1);
        chk(mem_req == 0, "R10 request after reset", 32'(mem_req), 0);
        chk(per_ready == 0, "R10 ready after reset", 32'(per_ready), 0);
        chk(cur_buf == 0, "R10 buffer flag after reset", 32'(cur_buf), 0);
        chk(blk_done == 0, "R10 done after reset", 32'(blk_done), 0);

        // R2: a zero count does not start the channel
        setup(0, 0, 0, 0, 0, 0, 1);
        start_block();
        feed_n = 3;
        wait_cyc(5);
        chk(per_ready == 0, "R2 zero count ignored (ready)", 32'(per_ready), 0);
        chk(sent == 0, "R2 zero count ignored (items)", sent, 0);
        chk(mem_req == 0, "R2 zero count ignored (request)", 32'(mem_req), 0);

        // R3: the request rises one cycle after the fill reaches 3 items
        setup(2, 3, 1, 0, 8, 0, 1);
        start_block();
        feed_n = 1; wait_cyc(4);
        chk(mem_req == 0, "R3 no request at 1 item", 32'(mem_req), 0);
        feed_n = 2; wait_cyc(4);
        chk(mem_req == 0, "R3 no request at 2 items", 32'(mem_req), 0);
        feed_n = 3; wait_cyc(1);
        chk(mem_req == 0, "R3 no request in the filling cycle", 32'(mem_req), 0);
        wait_cyc(1);
        chk(mem_req == 1, "R3 request one cycle after level", 32'(mem_req), 1);
        chk(mem_len == 2'd2, "R4 burst capped to level", 32'(mem_len), 2);
        feed_n = 8;
        wait_blocks(1, 200, "R7 block completes after level test");

        // R1: a full FIFO back-pressures; R4: the burst waits for grant
        setup(3, 3, 1, 0, 8, 0, 0);
        start_block();
        feed_n = 8;
        wait_cyc(10);
        chk(sent == 4, "R1 items accepted while space", sent, 4);
        chk(per_ready == 0, "R1 ready low when full", 32'(per_ready), 0);
        chk(mem_req == 1 && mem_len == 2'd3, "R4 burst held without grant", {mem_req, mem_len}, 32'h7);
        gnt_mode = 1;
        wait_blocks(1, 200, "R4 back-pressured block completes");
        chk(rcv == 8, "R2 item total after back-pressure", rcv, 8);

        // R8: double buffering, then swap disabled before the second block ends
        setup(0, 0, 0, 0, 3, 1, 2);
        cfg_base0 = 32'h0000_1000;
        cfg_base1 = 32'h0000_2000;
        start_block();
        feed_n = 6;
        wait_blocks(1, 200, "R8 first buffer completes");
        chk(cur_buf == 1, "R8 swapped after first block", 32'(cur_buf), 1);
        cfg_dbuf = 1'b0;
        wait_blocks(2, 200, "R8 second block runs without a start");
        wait_cyc(2);
        chk(cur_buf == 1, "R8 no swap once mode is off", 32'(cur_buf), 1);
        chk(per_ready == 0, "R9 stopped after last block", 32'(per_ready), 0);
        chk(rcv == 6, "R2 item total over two blocks", rcv, 6);

        // Sweep: level, burst length, burst on/off, item size, block size, grant pattern
        for (int t = 0; t < 4; t++) begin
            for (int b = 0; b < 4; b++) begin
                for (int be = 0; be < 2; be++) begin
                    for (int by = 0; by < 2; by++) begin
                        for (int ci = 0; ci < 3; ci++) begin
                            cnt = (ci == 0) ? 1 : (ci == 1) ? 5 : 9;
                            setup(t, b, be[0], by[0], cnt, 0, ((t + b + ci) % 2 == 1) ? 2 : 1);
                            start_block();
                            feed_n = cnt;
                            wait_blocks(1, 300, "R7 swept block completes");
                            wait_cyc(2);
                            chk(rcv == cnt, "R2 swept item total", rcv, cnt);
                            chk(per_ready == 0 && mem_req == 0, "R9 idle after single-buffer block",
                                {per_ready, mem_req}, 0);
                            chk(cur_buf == 0, "R9 buffer 0 in single-buffer mode", 32'(cur_buf), 0);
                        end
                    end
                end
            end
        end

        // R2: the largest block
        setup(3, 3, 1, 0, 65535, 0, 1);
        start_block();
        feed_n = 65535;
        wait_blocks(1, 120000, "R2 maximum block completes");
        chk(rcv == 65535, "R2 maximum item total", rcv, 65535);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule